// File: doc/BRIEF.md
# Test-Port Instruction Decoder and Data-Register Selector

This block sits beside an external test-port state machine and does the work that follows from the current instruction. It holds a 4-bit instruction shift stage and an active instruction, decodes the active instruction, and picks which data register is placed between the serial input and the serial output. It also decides what every guarded pin sees. A pin can follow the core logic, follow the boundary update latches, or be forced to high impedance. That choice is made apart from the choice of the shifted register, so a clamp can hold the pins at boundary values while only the one-bit bypass stage is shifted.

The state machine drives six one-hot strobes: capture, shift and update, each for the instruction path and for the data path. Shift stages move on the rising test clock, least significant bit first toward the output. The serial output is retimed on the falling edge. The data registers are a one-bit bypass stage, a 32-bit identification register (fixed code or user code), and a boundary register with one cell per pin plus its update latches.

Top module: `scan_instr_ctrl`

## Requirements
- R1: An asynchronous low reset puts IDCODE (0010) into the active instruction (BYPASS when HAS_ID is 0), clears the update latches and the serial output, and returns the pins to core control at once.
- R2: Instruction capture loads 0001 into the 4-bit shift stage, and its bits leave LSB first. The active instruction changes only on an instruction update.
- R3: BYPASS (1111) and every undefined opcode select a one-bit stage. That stage captures 0 and delays the serial data by one clock.
- R4: IDCODE (0010) selects a 32-bit register that captures {version[31:28], part[27:12], maker[11:1], 1'b1}.
- R5: USERCODE (0101) selects the same 32-bit register, which captures the user_code input on data capture.
- R6: SAMPLE/PRELOAD (0001) selects the boundary register. Data capture loads pin_in with bit i taken from pin i, and the pins stay under core control.
- R7: EXTEST (0000) selects the boundary register and drives every pin from its update latch with all output enables set.
- R8: CLAMP (0011) drives the pins from the update latches with all enables set, while the bypass stage is shifted.
- R9: HIGHZ (0100) clears every output enable, leaves pin_out following core_out, and shifts the bypass stage.
- R10: The serial output takes each new bit on the falling test-clock edge and holds it across the rising edge that follows.
- R11: The update latches load the boundary register only on a data update under SAMPLE/PRELOAD or EXTEST. They hold their value under every other instruction and strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial data in |
| capture_ir | input | 1 | Instruction capture strobe |
| shift_ir | input | 1 | Instruction shift strobe |
| update_ir | input | 1 | Instruction update strobe |
| capture_dr | input | 1 | Data capture strobe |
| shift_dr | input | 1 | Data shift strobe |
| update_dr | input | 1 | Data update strobe |
| core_out | input | NUM_PINS | Functional value from core logic per pin |
| core_oe | input | NUM_PINS | Functional output enable per pin |
| pin_in | input | NUM_PINS | Observed pin values for capture |
| user_code | input | 32 | User-programmed identification code |
| tdo | output | 1 | Serial data out |
| pin_out | output | NUM_PINS | Value driven to each pin |
| pin_oe | output | NUM_PINS | Output enable for each pin |

## Verification
The bench shifts four bits more than each selected register holds, so the length of the register can be seen: a wrong selection or an off-by-one chain shows up as the fed-in bits arriving early or late. It shifts a new instruction without the update strobe and checks that the pins keep their old mode; a decoder that bypassed the shift stage would switch pins in the middle of a shift. It runs a data update under CLAMP and checks that the pins do not move, which catches latches loaded under the wrong instruction. It pulls reset between clock edges to show that the pins leave boundary control with no clock, and it watches the serial output on both sides of the falling edge.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;
   localparam int IR_W = 4;
   localparam int ID_W = 32;

   localparam logic [IR_W-1:0] OP_EXTEST   = 4'b0000;
   localparam logic [IR_W-1:0] OP_SAMPLE   = 4'b0001;
   localparam logic [IR_W-1:0] OP_IDCODE   = 4'b0010;
   localparam logic [IR_W-1:0] OP_CLAMP    = 4'b0011;
   localparam logic [IR_W-1:0] OP_HIGHZ    = 4'b0100;
   localparam logic [IR_W-1:0] OP_USERCODE = 4'b0101;
   localparam logic [IR_W-1:0] OP_BYPASS   = 4'b1111;
   localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;

   typedef enum logic [1:0] {DR_BYP, DR_IDENT, DR_BOUND} dr_sel_e;
   typedef enum logic [1:0] {PIN_CORE, PIN_BOUND, PIN_OFF} pin_mode_e;

   typedef struct packed {
      dr_sel_e   dr;
      pin_mode_e pins;
      logic      use_user;
   } decode_t;

   function automatic decode_t decode_op(logic [IR_W-1:0] op, bit has_id);
      decode_t d;
      d = '{dr: DR_BYP, pins: PIN_CORE, use_user: 1'b0};
      unique case (op)
         OP_EXTEST:   d = '{dr: DR_BOUND, pins: PIN_BOUND, use_user: 1'b0};
         OP_SAMPLE:   d = '{dr: DR_BOUND, pins: PIN_CORE,  use_user: 1'b0};
         OP_IDCODE:   if (has_id) d = '{dr: DR_IDENT, pins: PIN_CORE, use_user: 1'b0};
         OP_USERCODE: if (has_id) d = '{dr: DR_IDENT, pins: PIN_CORE, use_user: 1'b1};
         OP_CLAMP:    d = '{dr: DR_BYP,   pins: PIN_BOUND, use_user: 1'b0};
         OP_HIGHZ:    d = '{dr: DR_BYP,   pins: PIN_OFF,   use_user: 1'b0};
         default:     d = '{dr: DR_BYP,   pins: PIN_CORE,  use_user: 1'b0};
      endcase
      return d;
   endfunction
endpackage

// File: rtl/scan_ir.sv
`timescale 1ns/1ps
module scan_ir
   import scan_pkg::*;
#(
   parameter bit HAS_ID = 1'b1
) (
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tdi,
   input  logic            capture,
   input  logic            shift,
   input  logic            update,
   output logic            ser_out,
   output logic [IR_W-1:0] active,
   output decode_t         dec
);
   localparam logic [IR_W-1:0] RESET_OP = HAS_ID ? OP_IDCODE : OP_BYPASS;

   logic [IR_W-1:0] sr_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)      sr_q <= IR_CAPTURE;
      else if (capture) sr_q <= IR_CAPTURE;
      else if (shift)   sr_q <= {tdi, sr_q[IR_W-1:1]};
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)     active <= RESET_OP;
      else if (update) active <= sr_q;
   end

   always_comb dec = decode_op(active, HAS_ID);
   assign ser_out = sr_q[0];
endmodule

// File: rtl/scan_dr_bank.sv
`timescale 1ns/1ps
module scan_dr_bank
   import scan_pkg::*;
#(
   parameter int              NUM_PINS = 4,
   parameter bit              HAS_ID   = 1'b1,
   parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_0001
) (
   input  logic                tck,
   input  logic                trst_n,
   input  logic                tdi,
   input  logic                capture,
   input  logic                shift,
   input  logic                update,
   input  decode_t             dec,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [ID_W-1:0]     user_code,
   output logic                ser_out,
   output logic [NUM_PINS-1:0] upd_lat
);
   logic                byp_q;
   logic                id_ser;
   logic [NUM_PINS-1:0] bsr_q;

   wire sel_byp   = (dec.dr == DR_BYP);
   wire sel_bound = (dec.dr == DR_BOUND);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                byp_q <= 1'b0;
      else if (capture && sel_byp) byp_q <= 1'b0;
      else if (shift && sel_byp)   byp_q <= tdi;
   end

   generate
      if (HAS_ID) begin : g_ident
         logic [ID_W-1:0] id_q;
         wire sel_id = (dec.dr == DR_IDENT);
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)                id_q <= ID_VALUE;
            else if (capture && sel_id) id_q <= dec.use_user ? user_code : ID_VALUE;
            else if (shift && sel_id)   id_q <= {tdi, id_q[ID_W-1:1]};
         end
         assign id_ser = id_q[0];
      end else begin : g_no_ident
         assign id_ser = 1'b0;
      end
   endgenerate

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                   bsr_q <= '0;
      else if (capture && sel_bound) bsr_q <= pin_in;
      else if (shift && sel_bound) begin
         if (NUM_PINS == 1) bsr_q <= tdi;
         else               bsr_q <= {tdi, bsr_q[NUM_PINS-1:1]};
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                  upd_lat <= '0;
      else if (update && sel_bound) upd_lat <= bsr_q;
   end

   always_comb begin
      unique case (dec.dr)
         DR_IDENT: ser_out = id_ser;
         DR_BOUND: ser_out = bsr_q[0];
         default:  ser_out = byp_q;
      endcase
   end
endmodule

// File: rtl/scan_pin_mux.sv
`timescale 1ns/1ps
module scan_pin_mux
   import scan_pkg::*;
#(
   parameter int NUM_PINS = 4
) (
   input  pin_mode_e           mode,
   input  logic [NUM_PINS-1:0] core_out,
   input  logic [NUM_PINS-1:0] core_oe,
   input  logic [NUM_PINS-1:0] upd_lat,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe
);
   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         always_comb begin
            unique case (mode)
               PIN_BOUND: begin pin_out[i] = upd_lat[i];  pin_oe[i] = 1'b1;       end
               PIN_OFF:   begin pin_out[i] = core_out[i]; pin_oe[i] = 1'b0;       end
               default:   begin pin_out[i] = core_out[i]; pin_oe[i] = core_oe[i]; end
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/scan_instr_ctrl.sv
`timescale 1ns/1ps
module scan_instr_ctrl
   import scan_pkg::*;
#(
   parameter int          NUM_PINS   = 4,
   parameter bit          HAS_ID     = 1'b1,
   parameter logic [3:0]  ID_VERSION = 4'h3,
   parameter logic [15:0] ID_PART    = 16'hA5C2,
   parameter logic [10:0] ID_MAKER   = 11'h2B6
) (
   input  logic                tck,
   input  logic                trst_n,
   input  logic                tdi,
   input  logic                capture_ir,
   input  logic                shift_ir,
   input  logic                update_ir,
   input  logic                capture_dr,
   input  logic                shift_dr,
   input  logic                update_dr,
   input  logic [NUM_PINS-1:0] core_out,
   input  logic [NUM_PINS-1:0] core_oe,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [31:0]         user_code,
   output logic                tdo,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe
);
   localparam logic [ID_W-1:0] ID_VALUE = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

   generate
      if (NUM_PINS < 1) begin : g_bad_pins
         $error("scan_instr_ctrl: NUM_PINS must be at least 1");
      end
      if (ID_W != 32) begin : g_bad_id
         $error("scan_instr_ctrl: identification register must be 32 bits");
      end
   endgenerate

   logic            ir_ser;
   logic            dr_ser;
   logic [IR_W-1:0] ir_active;
   decode_t         dec;
   logic [NUM_PINS-1:0] upd_lat;

   scan_ir #(.HAS_ID(HAS_ID)) u_ir (
      .tck(tck), .trst_n(trst_n), .tdi(tdi),
      .capture(capture_ir), .shift(shift_ir), .update(update_ir),
      .ser_out(ir_ser), .active(ir_active), .dec(dec)
   );

   scan_dr_bank #(.NUM_PINS(NUM_PINS), .HAS_ID(HAS_ID), .ID_VALUE(ID_VALUE)) u_dr (
      .tck(tck), .trst_n(trst_n), .tdi(tdi),
      .capture(capture_dr), .shift(shift_dr), .update(update_dr),
      .dec(dec), .pin_in(pin_in), .user_code(user_code),
      .ser_out(dr_ser), .upd_lat(upd_lat)
   );

   scan_pin_mux #(.NUM_PINS(NUM_PINS)) u_pins (
      .mode(dec.pins), .core_out(core_out), .core_oe(core_oe),
      .upd_lat(upd_lat), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)       tdo <= 1'b0;
      else if (shift_ir) tdo <= ir_ser;
      else if (shift_dr) tdo <= dr_ser;
   end
endmodule

// File: rtl/scan_instr_ctrl_chk.sv
`timescale 1ns/1ps
module scan_instr_ctrl_chk
   import scan_pkg::*;
#(
   parameter int NUM_PINS = 4
) (
   input logic                tck,
   input logic                trst_n,
   input logic                update_ir,
   input logic                update_dr,
   input logic [IR_W-1:0]     ir_active,
   input logic [NUM_PINS-1:0] upd_lat,
   input logic [NUM_PINS-1:0] core_out,
   input logic [NUM_PINS-1:0] core_oe,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe
);
   // R2
   ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      !update_ir |=> $stable(ir_active));

   // R11
   lat_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      !update_dr |=> $stable(upd_lat));

   // R7
   extest_pins_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (ir_active == OP_EXTEST) |-> (pin_out == upd_lat && pin_oe == '1));

   // R8
   clamp_pins_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (ir_active == OP_CLAMP) |-> (pin_out == upd_lat && pin_oe == '1));

   // R9
   highz_pins_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (ir_active == OP_HIGHZ) |-> (pin_oe == '0));

   // R6
   sample_pins_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (ir_active == OP_SAMPLE) |-> (pin_out == core_out && pin_oe == core_oe));
endmodule

bind scan_instr_ctrl scan_instr_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .tck(tck), .trst_n(trst_n), .update_ir(update_ir), .update_dr(update_dr),
   .ir_active(ir_active), .upd_lat(upd_lat), .core_out(core_out),
   .core_oe(core_oe), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/scan_instr_ctrl_tb.sv
`timescale 1ns/1ps
module scan_instr_ctrl_tb;
   localparam int NP = 4;
   localparam logic [31:0] ID_EXP = {4'h3, 16'hA5C2, 11'h2B6, 1'b1};
   localparam logic [31:0] UCODE  = 32'hC0DE_5A17;
   localparam logic [NP-1:0] CORE_OUT = 4'b0110;
   localparam logic [NP-1:0] CORE_OE  = 4'b0011;
   localparam logic [NP-1:0] PIN_IN   = 4'b1001;

   typedef struct packed {
      logic [3:0]  op;
      logic [5:0]  n;
      logic [31:0] cap;
      logic [39:0] din;
      logic [1:0]  mode;   // 0 core, 1 boundary, 2 off
      logic        ld;     // data update loads latches
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{op:4'b0010, n:6'd32, cap:ID_EXP,         din:40'h0000_0000_0B, mode:2'd0, ld:1'b0},
      '{op:4'b0101, n:6'd32, cap:UCODE,          din:40'h0000_0000_06, mode:2'd0, ld:1'b0},
      '{op:4'b0001, n:6'd4,  cap:{28'd0,PIN_IN}, din:40'h0000_0000_53, mode:2'd0, ld:1'b1},
      '{op:4'b0000, n:6'd4,  cap:{28'd0,PIN_IN}, din:40'h0000_0000_A9, mode:2'd1, ld:1'b1},
      '{op:4'b0011, n:6'd1,  cap:32'd0,          din:40'h0000_0000_3C, mode:2'd1, ld:1'b0},
      '{op:4'b0100, n:6'd1,  cap:32'd0,          din:40'h0000_0000_1D, mode:2'd2, ld:1'b0},
      '{op:4'b1111, n:6'd1,  cap:32'd0,          din:40'h0000_0000_16, mode:2'd0, ld:1'b0},
      '{op:4'b1010, n:6'd1,  cap:32'd0,          din:40'h0000_0000_0E, mode:2'd0, ld:1'b0}
   };

   logic tck = 1'b0, trst_n = 1'b0, tdi = 1'b0;
   logic capture_ir = 0, shift_ir = 0, update_ir = 0;
   logic capture_dr = 0, shift_dr = 0, update_dr = 0;
   logic [NP-1:0] core_out = CORE_OUT, core_oe = CORE_OE, pin_in = PIN_IN;
   logic [31:0] user_code = UCODE;
   logic tdo;
   logic [NP-1:0] pin_out, pin_oe;

   int checks = 0, fails = 0;
   logic [NP-1:0] lat = '0;

   always #4 tck = ~tck;

   scan_instr_ctrl u_dut (
      .tck(tck), .trst_n(trst_n), .tdi(tdi),
      .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
      .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
      .core_out(core_out), .core_oe(core_oe), .pin_in(pin_in), .user_code(user_code),
      .tdo(tdo), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // Entered and left just after a rising edge.
   task automatic run_ir(input logic [3:0] op, input bit do_upd, output logic [3:0] cap);
      capture_ir = 1; @(posedge tck); #1; capture_ir = 0; shift_ir = 1;
      for (int i = 0; i < 4; i++) begin
         tdi = op[i]; @(negedge tck); #1; cap[i] = tdo; @(posedge tck); #1;
      end
      shift_ir = 0;
      if (do_upd) begin update_ir = 1; @(posedge tck); #1; update_ir = 0; end
   endtask

   task automatic run_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
      dout = '0;
      capture_dr = 1; @(posedge tck); #1; capture_dr = 0; shift_dr = 1;
      for (int i = 0; i < n; i++) begin
         tdi = din[i]; @(negedge tck); #1; dout[i] = tdo; @(posedge tck); #1;
      end
      shift_dr = 0; update_dr = 1; @(posedge tck); #1; update_dr = 0;
   endtask

   task automatic check_pins(input logic [1:0] mode, input string req);
      logic [NP-1:0] eo, ee;
      case (mode)
         2'd1:    begin eo = lat;      ee = '1; end
         2'd2:    begin eo = CORE_OUT; ee = '0; end
         default: begin eo = CORE_OUT; ee = CORE_OE; end
      endcase
      check(pin_out == eo, req, "pin_out", 64'(pin_out), 64'(eo));
      check(pin_oe == ee, req, "pin_oe", 64'(pin_oe), 64'(ee));
   endtask

   initial begin
      repeat (100000) @(posedge tck);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [3:0]  icap;
      logic [63:0] dout, exp, msk;
      // R1: reset state
      #10;
      check(tdo == 1'b0, "R1", "tdo in reset", 64'(tdo), 64'd0);
      check_pins(2'd0, "R1");
      @(posedge tck); #1; trst_n = 1;
      @(posedge tck); #1;
      // R1, R4: identification selected without any instruction load
      run_dr(36, 64'h5, dout);
      exp = {28'd0, 4'h5, ID_EXP};
      check(dout[35:0] == exp[35:0], "R1", "reset selects ident", dout, exp);

      // table of instructions
      foreach (VECS[k]) begin
         run_ir(VECS[k].op, 1'b1, icap);
         check(icap == 4'b0001, "R2", "ir capture", 64'(icap), 64'd1);
         check_pins(VECS[k].mode, "R6-R9 pin mode after ir update");
         run_dr(VECS[k].n + 4, 64'(VECS[k].din), dout);
         msk = (64'd1 << (VECS[k].n + 4)) - 1;
         exp = ((64'(VECS[k].cap) & ((64'd1 << VECS[k].n) - 1)) | (64'(VECS[k].din) << VECS[k].n)) & msk;
         // R3 R4 R5 R6 R7 R8 R9 length and captured value
         check((dout & msk) == exp, "R3/R4/R5/R6", "dr shift out", dout & msk, exp);
         if (VECS[k].ld) lat = VECS[k].din[4 +: NP];
         // R11 latches move only under boundary instructions
         check_pins(VECS[k].mode, "R11 pins after dr update");
      end

      // R2: shifted instruction without update leaves mode untouched
      run_ir(4'b0000, 1'b0, icap);
      check_pins(2'd0, "R2 no update");
      update_ir = 1; @(posedge tck); #1; update_ir = 0;
      check_pins(2'd1, "R7 after update");

      // R10: tdo changes at falling edge only (load IDCODE first)
      run_ir(4'b0010, 1'b1, icap);
      capture_dr = 1; @(posedge tck); #1; capture_dr = 0; shift_dr = 1; tdi = 0;
      @(negedge tck); #1;
      check(tdo == ID_EXP[0], "R10", "first bit", 64'(tdo), 64'(ID_EXP[0]));
      @(posedge tck); #1;
      check(tdo == ID_EXP[0], "R10", "held across rising edge", 64'(tdo), 64'(ID_EXP[0]));
      @(negedge tck); #1;
      check(tdo == ID_EXP[1], "R10", "second bit at falling edge", 64'(tdo), 64'(ID_EXP[1]));
      @(posedge tck); #1; shift_dr = 0;

      // R1: asynchronous reset under EXTEST
      run_ir(4'b0000, 1'b1, icap);
      check_pins(2'd1, "R7 before reset");
      #2; trst_n = 0; #1;
      check_pins(2'd0, "R1 async reset pins");
      check(tdo == 1'b0, "R1", "async reset tdo", 64'(tdo), 64'd0);
      @(posedge tck); #1; trst_n = 1; lat = '0;
      @(posedge tck); #1;
      run_dr(32, 64'h0, dout);
      check(dout[31:0] == ID_EXP, "R1", "ident after async reset", dout, 64'(ID_EXP));
      run_ir(4'b0000, 1'b1, icap);
      check_pins(2'd1, "R1 latches cleared");
      finish_run();
   end
endmodule